// File: doc/BRIEF.md
# Reserved Write-Back Buffer Manager

This block owns the small pool of victim slots that sit between a second-level cache and the directory below it. A miss may go out only after it has set aside a slot, so that the line it later displaces always has somewhere to go. When the fill for that miss comes back, the block books one of the set-aside slots and looks at what the fill displaced. If nothing was displaced, the slot goes back to the pool. If something was displaced, the slot holds the outgoing messages until each port takes them. The upward port carries an invalidation that keeps the upper cache a subset of this one, or a request for the upper cache's dirty copy. The downward port carries a dirty write-back or a clean replacement notice to the directory.

Messages leave in a fixed order for each slot. The upward message goes first. For an upper cache that writes through, the downward message follows as soon as the upward one is accepted. For an upper cache that writes back, the downward message waits for the upper cache's answer. A positive answer supplies newer data. A negative answer means the upper cache held no dirty copy. Fills are taken in every cycle and never wait on either port. Each port serves its waiting slots oldest booking first.

Top module: `wbb_manager`

## Requirements
- R1: A reservation request (rsvReq) claims a free slot when rsvOk is high. rsvOk is low exactly when no slot is free, and a request made while rsvOk is low has no effect.
- R2: A fill with replKind 0 (no victim), or the unused code 3, returns its booked slot to the pool in the next cycle and produces no upward or downward message.
- R3: A fill with replKind 1 (shared victim) raises upValid in the next cycle with upIsWbReq=0 and the victim address. The message holds until upReady, no downward message follows, and the slot is then free.
- R4: A fill with replKind 2 (exclusive victim) and upperWriteBack=0 first presents the upward invalidation. dnValid for that slot rises only in the cycle after the upward message is accepted. The downward message is a write-back (dnIsWrb=1) carrying the fill's victim data when l2Dirty was set, and otherwise a replacement notice (dnIsWrb=0).
- R5: A fill with replKind 2 and upperWriteBack=1 presents an upward write-back request (upIsWbReq=1) whose upTag names the slot. The downward message waits for ackValid with a matching ackTag. A positive answer (ackPositive=1) yields a write-back with ackData. A negative answer yields a write-back with the stored victim data if l2Dirty was set, and otherwise a replacement notice.
- R6: A downward message stays valid until dnReady, and its slot becomes free in the next cycle.
- R7: A fill is accepted in any cycle in which a slot is reserved, whatever the state of upReady and dnReady.
- R8: Each port issues at most one message per cycle, choosing among its waiting slots the one booked earliest.
- R9: After reset no message is valid and rsvOk is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rsvReq | input | 1 | Set aside a slot for a miss about to issue |
| rsvOk | output | 1 | At least one slot is free |
| replyValid | input | 1 | A fill has returned in this cycle |
| replKind | input | 2 | Victim class: 0 none, 1 shared, 2 exclusive |
| replAddr | input | ADDR_W | Victim line address |
| replData | input | DATA_W | Victim data held by this cache |
| l2Dirty | input | 1 | Victim is dirty in this cache |
| upperWriteBack | input | 1 | Upper cache uses write-back policy |
| upValid | output | 1 | Upward message present |
| upReady | input | 1 | Upward port accepts |
| upIsWbReq | output | 1 | 1: write-back request, 0: invalidation |
| upTag | output | 4 | Slot number carried by the upward message |
| upAddr | output | ADDR_W | Line address of the upward message |
| ackValid | input | 1 | Upper cache answers a write-back request |
| ackTag | input | 4 | Slot the answer belongs to |
| ackPositive | input | 1 | Upper cache supplied dirty data |
| ackData | input | DATA_W | Data supplied by the upper cache |
| dnValid | output | 1 | Downward message present |
| dnReady | input | 1 | Downward port accepts |
| dnIsWrb | output | 1 | 1: write-back with data, 0: replacement notice |
| dnAddr | output | ADDR_W | Line address of the downward message |
| dnData | output | DATA_W | Data of the downward message |

## Verification
A new fill can be booked in the same cycle that the downward port accepts an older slot's write-back, and both events update slot state on the same edge. The bench provokes this by holding the downward port blocked with every slot occupied, then raising dnReady and a fresh exclusive fill together. The next cycle must show the new fill's invalidation on the upward port, the next-oldest write-back on the downward port and rsvOk high again. Once the new slot reaches the downward queue, it must still wait behind the older slots.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  localparam int unsigned SLOT_IDX_W = 4;

  typedef logic [SLOT_IDX_W-1:0] slotIdx_t;

  typedef enum logic [1:0] {
    VICTIM_NONE   = 2'd0,
    VICTIM_SHARED = 2'd1,
    VICTIM_EXCL   = 2'd2
  } victimKind_e;

  typedef enum logic [2:0] {
    SLOT_FREE,
    SLOT_RSVD,
    SLOT_UPPEND,
    SLOT_UPWAIT,
    SLOT_DNPEND
  } slotState_e;

  typedef struct packed {
    logic     bookEn;
    slotIdx_t bookIdx;
    logic     ackEn;
    logic     ackPos;
    slotIdx_t ackIdx;
    slotIdx_t upIdx;
    slotIdx_t dnIdx;
  } wbbStrobe_t;
endpackage

// File: rtl/wbb_ctrl.sv
module wbb_ctrl
  import wbb_pkg::*;
#(
  parameter int unsigned NSLOTS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rsvReq,
  output logic       rsvOk,
  input  logic       replyValid,
  input  logic [1:0] replKind,
  input  logic       upperWriteBack,
  output logic       upValid,
  input  logic       upReady,
  output logic       upIsWbReq,
  input  logic       ackValid,
  input  slotIdx_t   ackTag,
  input  logic       ackPositive,
  output logic       dnValid,
  input  logic       dnReady,
  output wbbStrobe_t strobe
);
  localparam int unsigned IDX_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1;

  slotState_e        stateQ [NSLOTS];
  logic [NSLOTS-1:0] olderQ [NSLOTS];  // olderQ[i][j]: slot j was booked before slot i
  logic [NSLOTS-1:0] needDownQ, upWbQ;
  logic [NSLOTS-1:0] freeVec, rsvdVec, upReq, dnReq;
  logic [IDX_W-1:0]  rsvLocal, bookLocal, upLocal, dnLocal, ackLocal;
  logic [NSLOTS-1:0] bookOneHot;
  logic              bookEn, ackHit;

  genvar g;
  generate
    for (g = 0; g < NSLOTS; g++) begin : g_vec
      assign freeVec[g] = (stateQ[g] == SLOT_FREE);
      assign rsvdVec[g] = (stateQ[g] == SLOT_RSVD);
      assign upReq[g]   = (stateQ[g] == SLOT_UPPEND);
      assign dnReq[g]   = (stateQ[g] == SLOT_DNPEND);
    end
  endgenerate

  always_comb begin
    rsvLocal  = '0;
    bookLocal = '0;
    for (int i = NSLOTS - 1; i >= 0; i--) begin
      if (freeVec[i]) rsvLocal = IDX_W'(i);
      if (rsvdVec[i]) bookLocal = IDX_W'(i);
    end
  end

  always_comb begin
    upLocal = '0;
    dnLocal = '0;
    for (int i = 0; i < NSLOTS; i++) begin
      if (upReq[i] && ((upReq & olderQ[i]) == '0)) upLocal = IDX_W'(i);
      if (dnReq[i] && ((dnReq & olderQ[i]) == '0)) dnLocal = IDX_W'(i);
    end
  end

  assign rsvOk      = |freeVec;
  assign upValid    = |upReq;
  assign dnValid    = |dnReq;
  assign upIsWbReq  = upWbQ[upLocal];
  assign bookEn     = replyValid && (|rsvdVec);
  assign bookOneHot = NSLOTS'(1) << bookLocal;
  assign ackLocal   = ackTag[IDX_W-1:0];
  assign ackHit     = ackValid && (32'(ackTag) < NSLOTS) && (stateQ[ackLocal] == SLOT_UPWAIT);

  always_comb begin
    strobe.bookEn  = bookEn;
    strobe.bookIdx = slotIdx_t'(bookLocal);
    strobe.ackEn   = ackHit;
    strobe.ackPos  = ackPositive;
    strobe.ackIdx  = ackTag;
    strobe.upIdx   = slotIdx_t'(upLocal);
    strobe.dnIdx   = slotIdx_t'(dnLocal);
  end

  // Every event below acts on a slot in a different state, so no two touch the same slot.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLOTS; i++) begin
        stateQ[i] <= SLOT_FREE;
        olderQ[i] <= '0;
      end
      needDownQ <= '0;
      upWbQ     <= '0;
    end else begin
      if (rsvReq && rsvOk) stateQ[rsvLocal] <= SLOT_RSVD;
      if (bookEn) begin
        case (replKind)
          VICTIM_SHARED: begin
            stateQ[bookLocal]    <= SLOT_UPPEND;
            needDownQ[bookLocal] <= 1'b0;
            upWbQ[bookLocal]     <= 1'b0;
          end
          VICTIM_EXCL: begin
            stateQ[bookLocal]    <= SLOT_UPPEND;
            needDownQ[bookLocal] <= 1'b1;
            upWbQ[bookLocal]     <= upperWriteBack;
          end
          default: stateQ[bookLocal] <= SLOT_FREE;
        endcase
        olderQ[bookLocal] <= ~bookOneHot;
        for (int j = 0; j < NSLOTS; j++) begin
          if (IDX_W'(j) != bookLocal) olderQ[j][bookLocal] <= 1'b0;
        end
      end
      if (upValid && upReady) begin
        if (upWbQ[upLocal])          stateQ[upLocal] <= SLOT_UPWAIT;
        else if (needDownQ[upLocal]) stateQ[upLocal] <= SLOT_DNPEND;
        else                         stateQ[upLocal] <= SLOT_FREE;
      end
      if (ackHit) stateQ[ackLocal] <= SLOT_DNPEND;
      if (dnValid && dnReady) stateQ[dnLocal] <= SLOT_FREE;
    end
  end
endmodule

// File: rtl/wbb_datapath.sv
module wbb_datapath
  import wbb_pkg::*;
#(
  parameter int unsigned NSLOTS = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  wbbStrobe_t        strobe,
  input  logic [ADDR_W-1:0] replAddr,
  input  logic [DATA_W-1:0] replData,
  input  logic              l2Dirty,
  input  logic [DATA_W-1:0] ackData,
  output logic [ADDR_W-1:0] upAddr,
  output logic [ADDR_W-1:0] dnAddr,
  output logic [DATA_W-1:0] dnData,
  output logic              dnIsWrb
);
  logic [ADDR_W-1:0] addrQ [NSLOTS];
  logic [DATA_W-1:0] dataQ [NSLOTS];
  logic [NSLOTS-1:0] dirtyQ;

  genvar g;
  generate
    for (g = 0; g < NSLOTS; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) begin
          addrQ[g]  <= '0;
          dataQ[g]  <= '0;
          dirtyQ[g] <= 1'b0;
        end else if (strobe.bookEn && strobe.bookIdx == slotIdx_t'(g)) begin
          addrQ[g]  <= replAddr;
          dataQ[g]  <= replData;
          dirtyQ[g] <= l2Dirty;
        end else if (strobe.ackEn && strobe.ackPos && strobe.ackIdx == slotIdx_t'(g)) begin
          dataQ[g]  <= ackData;
          dirtyQ[g] <= 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    upAddr  = '0;
    dnAddr  = '0;
    dnData  = '0;
    dnIsWrb = 1'b0;
    for (int i = 0; i < NSLOTS; i++) begin
      if (strobe.upIdx == slotIdx_t'(i)) upAddr = addrQ[i];
      if (strobe.dnIdx == slotIdx_t'(i)) begin
        dnAddr  = addrQ[i];
        dnData  = dataQ[i];
        dnIsWrb = dirtyQ[i];
      end
    end
  end
endmodule

// File: rtl/wbb_manager.sv
module wbb_manager
  import wbb_pkg::*;
#(
  parameter int unsigned NSLOTS = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rsvReq,
  output logic                  rsvOk,
  input  logic                  replyValid,
  input  logic [1:0]            replKind,
  input  logic [ADDR_W-1:0]     replAddr,
  input  logic [DATA_W-1:0]     replData,
  input  logic                  l2Dirty,
  input  logic                  upperWriteBack,
  output logic                  upValid,
  input  logic                  upReady,
  output logic                  upIsWbReq,
  output logic [SLOT_IDX_W-1:0] upTag,
  output logic [ADDR_W-1:0]     upAddr,
  input  logic                  ackValid,
  input  logic [SLOT_IDX_W-1:0] ackTag,
  input  logic                  ackPositive,
  input  logic [DATA_W-1:0]     ackData,
  output logic                  dnValid,
  input  logic                  dnReady,
  output logic                  dnIsWrb,
  output logic [ADDR_W-1:0]     dnAddr,
  output logic [DATA_W-1:0]     dnData
);
  wbbStrobe_t strobe;

  wbb_ctrl #(.NSLOTS(NSLOTS)) u_ctrl (
    .clk(clk), .rst(rst), .rsvReq(rsvReq), .rsvOk(rsvOk),
    .replyValid(replyValid), .replKind(replKind), .upperWriteBack(upperWriteBack),
    .upValid(upValid), .upReady(upReady), .upIsWbReq(upIsWbReq),
    .ackValid(ackValid), .ackTag(ackTag), .ackPositive(ackPositive),
    .dnValid(dnValid), .dnReady(dnReady), .strobe(strobe)
  );

  wbb_datapath #(.NSLOTS(NSLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst(rst), .strobe(strobe), .replAddr(replAddr), .replData(replData),
    .l2Dirty(l2Dirty), .ackData(ackData), .upAddr(upAddr), .dnAddr(dnAddr),
    .dnData(dnData), .dnIsWrb(dnIsWrb)
  );

  assign upTag = strobe.upIdx;
endmodule

// File: rtl/wbb_checker.sv
module wbb_checker #(
  parameter int unsigned NSLOTS = 4
) (
  input logic clk,
  input logic rst,
  input logic rsvReq,
  input logic rsvOk,
  input logic replyValid,
  input logic upValid,
  input logic upReady,
  input logic dnValid,
  input logic dnReady
);
  int unsigned rsvdCnt;

  always_ff @(posedge clk) begin
    if (rst) rsvdCnt <= 0;
    else rsvdCnt <= rsvdCnt + ((rsvReq && rsvOk) ? 1 : 0) - ((replyValid && rsvdCnt != 0) ? 1 : 0);
  end

  a_r1_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (rsvdCnt == NSLOTS) |-> !rsvOk);

  a_r7_reply_has_booking: assert property (@(posedge clk) disable iff (rst)
    replyValid |-> (rsvdCnt != 0));

  a_r3_up_held: assert property (@(posedge clk) disable iff (rst)
    (upValid && !upReady) |=> upValid);

  a_r6_dn_held: assert property (@(posedge clk) disable iff (rst)
    (dnValid && !dnReady) |=> dnValid);

  a_r9_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!upValid && !dnValid && rsvOk));
endmodule

bind wbb_manager wbb_checker #(.NSLOTS(NSLOTS)) u_wbbChecker (
  .clk(clk), .rst(rst), .rsvReq(rsvReq), .rsvOk(rsvOk), .replyValid(replyValid),
  .upValid(upValid), .upReady(upReady), .dnValid(dnValid), .dnReady(dnReady)
);

// File: tb/wbb_manager_bench.sv
`timescale 1ns/1ps
module wbb_manager_bench;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rsvReq = 1'b0, rsvOk;
  logic replyValid = 1'b0;
  logic [1:0] replKind = 2'd0;
  logic [ADDR_W-1:0] replAddr = '0;
  logic [DATA_W-1:0] replData = '0;
  logic l2Dirty = 1'b0, upperWriteBack = 1'b0;
  logic upValid, upReady = 1'b0, upIsWbReq;
  logic [3:0] upTag;
  logic [ADDR_W-1:0] upAddr;
  logic ackValid = 1'b0, ackPositive = 1'b0;
  logic [3:0] ackTag = '0;
  logic [DATA_W-1:0] ackData = '0;
  logic dnValid, dnReady = 1'b0, dnIsWrb;
  logic [ADDR_W-1:0] dnAddr;
  logic [DATA_W-1:0] dnData;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  wbb_manager u_wbb_manager (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reserve(input int n);
    rsvReq = 1'b1;
    repeat (n) step();
    rsvReq = 1'b0;
  endtask

  task automatic reply(input logic [1:0] kind, input logic [31:0] addr, input logic dirty);
    replyValid = 1'b1;
    replKind   = kind;
    replAddr   = addr;
    replData   = {addr, ~addr};
    l2Dirty    = dirty;
    step();
    replyValid = 1'b0;
  endtask

  // R1: all four slots free is shown by exactly four reservations filling the pool
  task automatic expectAllFree(input string req);
    reserve(3);
    chk({req, " pool free (R1)"}, 64'(rsvOk), 64'd1);
    reserve(1);
    chk({req, " pool full (R1)"}, 64'(rsvOk), 64'd0);
    repeat (4) reply(2'd0, 32'h0, 1'b0);
  endtask

  task automatic testReset();
    chk("R9 upValid", 64'(upValid), 64'd0);
    chk("R9 dnValid", 64'(dnValid), 64'd0);
    chk("R9 rsvOk", 64'(rsvOk), 64'd1);
  endtask

  task automatic testReserveNone();
    reserve(4);
    chk("R1 full", 64'(rsvOk), 64'd0);
    reserve(1);  // ignored while full
    chk("R1 ignored", 64'(rsvOk), 64'd0);
    reply(2'd0, 32'h100, 1'b1);
    chk("R2 freed", 64'(rsvOk), 64'd1);
    chk("R2 no up", 64'(upValid), 64'd0);
    chk("R2 no dn", 64'(dnValid), 64'd0);
    reply(2'd3, 32'h104, 1'b1);
    chk("R2 code3 no up", 64'(upValid), 64'd0);
    reply(2'd0, 32'h108, 1'b0);
    reply(2'd0, 32'h10c, 1'b0);
    chk("R2 quiet dn", 64'(dnValid), 64'd0);
    expectAllFree("R2");
  endtask

  task automatic testShared();
    upReady = 1'b0;
    dnReady = 1'b1;
    reserve(1);
    reply(2'd1, 32'h2000, 1'b1);
    chk("R3 upValid", 64'(upValid), 64'd1);
    chk("R3 inval kind", 64'(upIsWbReq), 64'd0);
    chk("R3 upAddr", 64'(upAddr), 64'h2000);
    step();
    chk("R3 held", 64'(upValid), 64'd1);
    upReady = 1'b1;
    step();
    upReady = 1'b0;
    chk("R3 up done", 64'(upValid), 64'd0);
    chk("R3 no dn", 64'(dnValid), 64'd0);
    step();
    chk("R3 still no dn", 64'(dnValid), 64'd0);
    expectAllFree("R3");
  endtask

  task automatic testExclThrough(input logic dirty);
    upperWriteBack = 1'b0;
    upReady = 1'b0;
    dnReady = 1'b1;
    reserve(1);
    reply(2'd2, 32'h3000, dirty);
    chk("R4 up first", 64'(upValid), 64'd1);
    chk("R4 inval kind", 64'(upIsWbReq), 64'd0);
    chk("R4 dn waits", 64'(dnValid), 64'd0);
    step();
    chk("R4 dn still waits", 64'(dnValid), 64'd0);
    upReady = 1'b1;
    step();
    upReady = 1'b0;
    chk("R4 dn after up", 64'(dnValid), 64'd1);
    chk("R4 wrb or repl", 64'(dnIsWrb), 64'(dirty));
    chk("R4 dnAddr", 64'(dnAddr), 64'h3000);
    if (dirty) chk("R4 dnData", dnData, {32'h3000, ~32'h3000});
    step();
    chk("R6 dn freed", 64'(dnValid), 64'd0);
    expectAllFree("R4");
  endtask

  task automatic testExclBack(input logic dirty, input logic positive);
    logic [3:0] tag;
    upperWriteBack = 1'b1;
    upReady = 1'b1;
    dnReady = 1'b0;
    reserve(1);
    reply(2'd2, 32'h4000, dirty);
    chk("R5 up present", 64'(upValid), 64'd1);
    chk("R5 wb request", 64'(upIsWbReq), 64'd1);
    tag = upTag;
    step();
    upReady = 1'b0;
    chk("R5 up taken", 64'(upValid), 64'd0);
    chk("R5 dn waits ack", 64'(dnValid), 64'd0);
    step();
    chk("R5 dn still waits", 64'(dnValid), 64'd0);
    ackValid = 1'b1;
    ackTag = tag;
    ackPositive = positive;
    ackData = 64'hA5A5_0000_0000_5A5A;
    step();
    ackValid = 1'b0;
    chk("R5 dn after ack", 64'(dnValid), 64'd1);
    chk("R5 dn kind", 64'(dnIsWrb), 64'(dirty | positive));
    if (positive) chk("R5 upper data", dnData, 64'hA5A5_0000_0000_5A5A);
    else if (dirty) chk("R5 own data", dnData, {32'h4000, ~32'h4000});
    dnReady = 1'b1;
    step();
    dnReady = 1'b0;
    chk("R6 dn freed", 64'(dnValid), 64'd0);
    upperWriteBack = 1'b0;
    expectAllFree("R5");
  endtask

  task automatic testOrderConcurrent();
    upperWriteBack = 1'b0;
    upReady = 1'b0;
    dnReady = 1'b0;
    reserve(4);
    reply(2'd2, 32'h5001, 1'b1);
    reply(2'd2, 32'h5002, 1'b1);
    reply(2'd2, 32'h5003, 1'b1);
    chk("R8 up oldest", 64'(upAddr), 64'h5001);
    upReady = 1'b1;
    step();
    chk("R8 up one per cycle", 64'(upAddr), 64'h5002);
    chk("R4 first dn", 64'(dnAddr), 64'h5001);
    step();
    chk("R8 up third", 64'(upAddr), 64'h5003);
    step();
    upReady = 1'b0;
    chk("R8 up drained", 64'(upValid), 64'd0);
    step();
    chk("R6 dn held", 64'(dnValid), 64'd1);
    chk("R6 dn held addr", 64'(dnAddr), 64'h5001);
    chk("R1 pool full", 64'(rsvOk), 64'd0);
    dnReady = 1'b1;
    reply(2'd2, 32'h5004, 1'b0);  // booked in the cycle the oldest leaves
    dnReady = 1'b0;
    chk("R7 fill taken", 64'(upAddr), 64'h5004);
    chk("R7 up valid", 64'(upValid), 64'd1);
    chk("R8 dn next oldest", 64'(dnAddr), 64'h5002);
    chk("R6 slot freed", 64'(rsvOk), 64'd1);
    upReady = 1'b1;
    step();
    upReady = 1'b0;
    chk("R8 young waits", 64'(dnAddr), 64'h5002);
    dnReady = 1'b1;
    step();
    chk("R8 dn third", 64'(dnAddr), 64'h5003);
    step();
    chk("R8 dn newest", 64'(dnAddr), 64'h5004);
    chk("R4 clean repl", 64'(dnIsWrb), 64'd0);
    step();
    dnReady = 1'b0;
    chk("R6 all out", 64'(dnValid), 64'd0);
    expectAllFree("R8");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL timeout all-requirements actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    rst = 1'b0;
    step();
    testReset();
    testReserveNone();
    testShared();
    testExclThrough(1'b1);
    testExclThrough(1'b0);
    testExclBack(1'b0, 1'b1);
    testExclBack(1'b1, 1'b0);
    testExclBack(1'b0, 1'b0);
    testOrderConcurrent();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule